// File: doc/BRIEF.md
# I2C Bus Timeout Monitor

This block sits beside an I2C controller and watches the SCL and SDA pins for conditions that last too long. Both pins first pass through a two-flop synchronizer. A main timer measures one of two conditions, and a mode input picks which. In clock-low mode it measures how long SCL stays low, which catches a target that stretches the clock without end. In idle mode it measures how long both lines stay high together. Each timer tick is 2048 clock cycles long, so a 12-bit threshold T gives a limit of (T + 1) × 2048 cycles. For example, T = 22 on a 32 MHz clock gives roughly 1.5 ms.

A second, extended timer has its own enable. It adds up every cycle that SCL is low across a whole transaction and is cleared only by a STOP condition. This bounds the total stretch within one transfer, even when each single low phase is short.

Each timer sets its own sticky flag. One clear input clears both flags. An interrupt output follows the flags when the interrupt enable is set. Configuration arrives as plain register-style inputs.

Top module: `scl_timeout_mon`

## Requirements
- R1: `scl_in` and `sda_in` each pass through two flip-flops before any logic uses them. A change on a pin therefore reaches the timers two clock edges later.
- R2: In clock-low mode (`cfg_idle_mode` = 0) with `cfg_main_en` = 1, `tmo_main` rises one cycle after the synchronized SCL has been low for (`cfg_thr_main` + 1) × 2048 consecutive cycles.
- R3: The main count returns to zero in any cycle where its watched condition is false. Separate short episodes never add up to a timeout.
- R4: In idle mode (`cfg_idle_mode` = 1), the main timer's condition is synchronized SCL = 1 and synchronized SDA = 1, with the same limit as R2.
- R5: While `cfg_main_en` = 0 the main count is held at zero and `tmo_main` never rises.
- R6: With `cfg_ext_en` = 1, the extended timer counts every cycle in which synchronized SCL is 0, and keeps its count while SCL is high. `tmo_ext` rises one cycle after the running total reaches (`cfg_thr_ext` + 1) × 2048.
- R7: A STOP condition clears the extended count. A STOP is a rising edge of synchronized SDA while synchronized SCL is 1.
- R8: While `cfg_ext_en` = 0 the extended count is held at zero and `tmo_ext` never rises.
- R9: Each flag stays set until `flag_clr` is 1 at a clock edge. If a timeout event and `flag_clr` fall in the same cycle, the flag is set.
- R10: `err_irq` equals `cfg_irq_en` AND (`tmo_main` OR `tmo_ext`), with no added delay.
- R11: Each timer produces at most one event per episode. After it fires, it does not fire again until its count restarts (R3, R5, R7 or R8), even if the flag has been cleared.
- R12: After reset both flags and `err_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL pin level |
| sda_in | input | 1 | Raw SDA pin level |
| cfg_thr_main | input | 12 | Main threshold T; limit (T+1)×2048 cycles |
| cfg_idle_mode | input | 1 | 0: measure SCL low; 1: measure bus idle |
| cfg_main_en | input | 1 | Main timer enable |
| cfg_thr_ext | input | 12 | Extended threshold; limit (T+1)×2048 cycles |
| cfg_ext_en | input | 1 | Extended timer enable |
| cfg_irq_en | input | 1 | Error interrupt enable |
| flag_clr | input | 1 | Clears both sticky flags |
| tmo_main | output | 1 | Sticky main timeout flag |
| tmo_ext | output | 1 | Sticky extended timeout flag |
| err_irq | output | 1 | Error interrupt |

## Verification
The bench targets the following corner cases:

- **Exact firing cycle.** The timeout must fire on the exact cycle implied by the two synchronizer stages. The threshold must be inclusive; an off-by-one limit would move the flag a cycle early or late.
- **Split low phases.** Two low phases, each shorter than the limit but longer together, must not fire the main timer. A counter that is not restarted would fire.
- **Clear during a held condition.** A clear while the condition is still held must leave the flag low. A timer that re-arms after firing would set it again 2048 cycles later.
- **Set and clear in the same cycle.** The bench holds `flag_clr` high through an event. If the clear took priority, the event would be lost.
- **STOP versus high SCL.** The extended timer is fed partial stretches split by an SCL-high gap, then by a STOP. A timer that cleared on any SCL-high phase would miss the first case; one that ignored STOP would fire in the second.

// File: rtl/scl_tmo_pkg.sv
package scl_tmo_pkg;
  // Threshold field width and fixed prescale (2**11 = 2048 cycles per tick)
  localparam int TMO_THR_W      = 12;
  localparam int TMO_PRESC_LOG2 = 11;
  localparam int TMO_SYNC_STG   = 2;

  // Which condition the main timer watches
  typedef enum logic {
    WATCH_SCL_LOW  = 1'b0,
    WATCH_BUS_IDLE = 1'b1
  } watch_mode_e;
endpackage

// File: rtl/scl_tmo_sync.sv
module scl_tmo_sync #(
  parameter int             W      = 2,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign stg_d[g] = din;
      end else begin : g_rest
        assign stg_d[g] = stg_q[g-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= RST_VAL;
        else        stg_q[g] <= stg_d[g];
      end
    end
  endgenerate

  assign dout = stg_q[STAGES-1];

  // R1: the output is the input delayed by exactly STAGES edges (checked for two stages)
  generate
    if (STAGES == 2) begin : g_lat_chk
      sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n, 2) |-> dout == $past(din, 2));
    end
  endgenerate
endmodule

// File: rtl/scl_tmo_timer.sv
module scl_tmo_timer #(
  parameter int THR_W      = 12,
  parameter int PRESC_LOG2 = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [THR_W-1:0] thr,
  output logic             evt
);
  // Low PRESC_LOG2 bits act as the fixed prescaler, upper bits count ticks.
  localparam int CNT_W = THR_W + PRESC_LOG2;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] limit;

  assign limit = {thr, {PRESC_LOG2{1'b1}}};

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    evt    = 1'b0;
    if (restart) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (run && !done_q) begin
      if (cnt_q == limit) begin
        evt    = 1'b1;
        done_d = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  // R11
  single_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);

  // R11
  done_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(run));
endmodule

// File: rtl/scl_timeout_mon.sv
module scl_timeout_mon
  import scl_tmo_pkg::*;
#(
  parameter int THR_W      = TMO_THR_W,
  parameter int PRESC_LOG2 = TMO_PRESC_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [THR_W-1:0] cfg_thr_main,
  input  logic             cfg_idle_mode,
  input  logic             cfg_main_en,
  input  logic [THR_W-1:0] cfg_thr_ext,
  input  logic             cfg_ext_en,
  input  logic             cfg_irq_en,
  input  logic             flag_clr,
  output logic             tmo_main,
  output logic             tmo_ext,
  output logic             err_irq
);
  logic [1:0]  bus_s;
  logic        scl_s, sda_s;
  logic        sda_d_q;
  logic        stop_det;
  logic        main_cond, main_act;
  logic        ext_run, ext_restart;
  logic        main_evt, ext_evt;
  logic        main_flag_q, main_flag_d;
  logic        ext_flag_q, ext_flag_d;
  watch_mode_e mode;

  // Synchronizers for both bus lines, idle level high
  scl_tmo_sync #(
    .W      (2),
    .STAGES (TMO_SYNC_STG),
    .RST_VAL(2'b11)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({scl_in, sda_in}),
    .dout (bus_s)
  );

  assign scl_s = bus_s[1];
  assign sda_s = bus_s[0];

  // Previous synchronized SDA for STOP edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sda_d_q <= 1'b1;
    else        sda_d_q <= sda_s;
  end

  assign stop_det = scl_s && sda_s && !sda_d_q;

  // Main timer condition selection
  assign mode = watch_mode_e'(cfg_idle_mode);

  always_comb begin
    case (mode)
      WATCH_BUS_IDLE: main_cond = scl_s && sda_s;
      default:        main_cond = !scl_s;
    endcase
  end

  assign main_act    = cfg_main_en && main_cond;
  assign ext_run     = cfg_ext_en && !scl_s;
  assign ext_restart = !cfg_ext_en || stop_det;

  scl_tmo_timer #(
    .THR_W     (THR_W),
    .PRESC_LOG2(PRESC_LOG2)
  ) u_main_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (main_act),
    .restart(!main_act),
    .thr    (cfg_thr_main),
    .evt    (main_evt)
  );

  scl_tmo_timer #(
    .THR_W     (THR_W),
    .PRESC_LOG2(PRESC_LOG2)
  ) u_ext_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (ext_run),
    .restart(ext_restart),
    .thr    (cfg_thr_ext),
    .evt    (ext_evt)
  );

  // Sticky flags: a new event wins over a clear in the same cycle
  always_comb begin
    main_flag_d = main_flag_q;
    ext_flag_d  = ext_flag_q;
    if (main_evt)      main_flag_d = 1'b1;
    else if (flag_clr) main_flag_d = 1'b0;
    if (ext_evt)       ext_flag_d  = 1'b1;
    else if (flag_clr) ext_flag_d  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_flag_q <= 1'b0;
      ext_flag_q  <= 1'b0;
    end else begin
      main_flag_q <= main_flag_d;
      ext_flag_q  <= ext_flag_d;
    end
  end

  assign tmo_main = main_flag_q;
  assign tmo_ext  = ext_flag_q;
  assign err_irq  = cfg_irq_en && (main_flag_q || ext_flag_q);

  // R5
  main_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_main) |-> $past(cfg_main_en));

  // R2
  scl_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tmo_main) && !$past(cfg_idle_mode)) |-> !$past(scl_s));

  // R4
  idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tmo_main) && $past(cfg_idle_mode)) |-> $past(scl_s && sda_s));

  // R6
  ext_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_ext) |-> ($past(cfg_ext_en) && !$past(scl_s)));

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_main && !flag_clr) |=> tmo_main);
endmodule

// File: tb/sim_scl_timeout_mon.sv
`timescale 1ns/1ps
module sim_scl_timeout_mon;
  localparam int TICK = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_in = 1'b1, sda_in = 1'b1;
  logic [11:0] cfg_thr_main = '0, cfg_thr_ext = '0;
  logic        cfg_idle_mode = 1'b0, cfg_main_en = 1'b0, cfg_ext_en = 1'b0;
  logic        cfg_irq_en = 1'b0, flag_clr = 1'b0;
  logic        tmo_main, tmo_ext, err_irq;

  int    vectors = 0;
  int    miscomp = 0;
  int    cyc = 0;
  string cur_req = "R12";

  always #2 clk = ~clk;

  scl_timeout_mon u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .cfg_thr_main(cfg_thr_main), .cfg_idle_mode(cfg_idle_mode),
    .cfg_main_en(cfg_main_en), .cfg_thr_ext(cfg_thr_ext),
    .cfg_ext_en(cfg_ext_en), .cfg_irq_en(cfg_irq_en), .flag_clr(flag_clr),
    .tmo_main(tmo_main), .tmo_ext(tmo_ext), .err_irq(err_irq)
  );

  // Behavioural reference: pin history queues and integer run lengths
  bit scl_q[$] = '{1'b1, 1'b1};
  bit sda_q[$] = '{1'b1, 1'b1};
  bit sda_prev = 1'b1;
  int run_a = 0, run_b = 0;
  bit fired_a = 0, fired_b = 0;
  bit e_fa = 0, e_fb = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      scl_q = '{1'b1, 1'b1}; sda_q = '{1'b1, 1'b1}; sda_prev = 1'b1;
      run_a = 0; run_b = 0; fired_a = 0; fired_b = 0; e_fa = 0; e_fb = 0;
    end else begin
      bit seen_scl, seen_sda, cond_a, ev_a, ev_b, stop;
      int lim_a, lim_b;
      seen_scl = scl_q[0];   // R1: value from two edges ago
      seen_sda = sda_q[0];
      lim_a = (int'(cfg_thr_main) + 1) * TICK;
      lim_b = (int'(cfg_thr_ext) + 1) * TICK;
      cond_a = cfg_main_en && (cfg_idle_mode ? (seen_scl && seen_sda) : !seen_scl);
      ev_a = 0;
      if (!cond_a) begin
        run_a = 0; fired_a = 0;
      end else if (!fired_a) begin
        run_a++;
        if (run_a == lim_a) begin ev_a = 1; fired_a = 1; run_a = 0; end
      end
      stop = seen_scl && seen_sda && !sda_prev;
      ev_b = 0;
      if (!cfg_ext_en || stop) begin
        run_b = 0; fired_b = 0;
      end else if (!seen_scl && !fired_b) begin
        run_b++;
        if (run_b == lim_b) begin ev_b = 1; fired_b = 1; run_b = 0; end
      end
      if (ev_a) e_fa = 1; else if (flag_clr) e_fa = 0;
      if (ev_b) e_fb = 1; else if (flag_clr) e_fb = 0;
      sda_prev = seen_sda;
      void'(scl_q.pop_front()); scl_q.push_back(scl_in);
      void'(sda_q.pop_front()); sda_q.push_back(sda_in);
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit e_irq;
      e_irq = cfg_irq_en && (e_fa || e_fb);
      vectors++;
      if (tmo_main !== e_fa || tmo_ext !== e_fb || err_irq !== e_irq) begin
        miscomp++;
        $display("FAIL %s t=%0t main/ext/irq actual=%b%b%b expected=%b%b%b",
                 cur_req, $time, tmo_main, tmo_ext, err_irq, e_fa, e_fb, e_irq);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      miscomp++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
    end
  end

  task automatic hold(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    // R12: reset state
    hold(3);
    @(negedge clk);
    vectors++;
    if (tmo_main !== 1'b0 || tmo_ext !== 1'b0 || err_irq !== 1'b0) begin
      miscomp++;
      $display("FAIL R12 reset actual=%b%b%b expected=000", tmo_main, tmo_ext, err_irq);
    end
    hold(1);
    rst_n = 1'b1;
    hold(5);

    // R2 / R1: SCL held low past one tick with threshold 0
    cur_req = "R2"; cfg_main_en = 1; cfg_thr_main = 12'd0; cfg_irq_en = 1;
    scl_in = 0; hold(TICK + 20);
    // R11: clear while still low, must not refire
    cur_req = "R11"; flag_clr = 1; hold(1); flag_clr = 0; hold(2 * TICK + 100);
    scl_in = 1; hold(10);

    // R3: two short lows separated by a high never add up
    cur_req = "R3"; cfg_thr_main = 12'd1;
    scl_in = 0; hold(3000); scl_in = 1; hold(3);
    scl_in = 0; hold(3000); scl_in = 1; hold(10);
    cur_req = "R2"; scl_in = 0; hold(2 * TICK + 50); scl_in = 1; hold(10);
    flag_clr = 1; hold(1); flag_clr = 0; hold(5);

    // R9: clear held through the event; event still sets the flag
    cur_req = "R9"; cfg_thr_main = 12'd0; flag_clr = 1;
    scl_in = 0; hold(TICK + 10); flag_clr = 0; scl_in = 1; hold(10);
    scl_in = 0; hold(TICK + 10); hold(50); scl_in = 1; hold(10);

    // R10: interrupt follows enable with flag set
    cur_req = "R10"; cfg_irq_en = 0; hold(20); cfg_irq_en = 1; hold(20);
    flag_clr = 1; hold(1); flag_clr = 0; hold(5);

    // R4: idle mode
    cur_req = "R4"; cfg_idle_mode = 1; scl_in = 1; sda_in = 1; hold(TICK + 30);
    flag_clr = 1; hold(1); flag_clr = 0; hold(5);
    for (int i = 0; i < 4; i++) begin
      sda_in = 0; hold(4); sda_in = 1; hold(1500);
    end
    sda_in = 0; hold(20); cfg_idle_mode = 0; scl_in = 0; hold(5);

    // R5: main disabled, long low does nothing
    cur_req = "R5"; cfg_main_en = 0; scl_in = 0; sda_in = 1; hold(3 * TICK);
    scl_in = 1; hold(10);

    // R6: extended timer accumulates across SCL-high gaps
    cur_req = "R6"; cfg_ext_en = 1; cfg_thr_ext = 12'd1;
    for (int i = 0; i < 3; i++) begin
      scl_in = 0; hold(1500); scl_in = 1; hold(100);
    end
    hold(10); flag_clr = 1; hold(1); flag_clr = 0; hold(5);

    // R7: STOP between two partial stretches clears the total
    cur_req = "R7"; sda_in = 1; scl_in = 1; hold(5); sda_in = 0; hold(5); sda_in = 1; hold(10);
    scl_in = 0; sda_in = 0; hold(3000);
    scl_in = 1; hold(5); sda_in = 1; hold(5);
    scl_in = 0; hold(3000); scl_in = 1; hold(10);
    sda_in = 0; hold(5); sda_in = 1; hold(10);

    // R8: extended timer disabled
    cur_req = "R8"; cfg_ext_en = 0; scl_in = 0; hold(3 * TICK); scl_in = 1; hold(10);

    // R2: threshold 2 with main enabled, both timers on
    cur_req = "R2"; cfg_main_en = 1; cfg_thr_main = 12'd2; cfg_ext_en = 1; cfg_thr_ext = 12'd0;
    scl_in = 0; hold(3 * TICK + 40); scl_in = 1; hold(20);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end
endmodule